// File: doc/BRIEF.md
# NAND Page-Read Sequencer

This block walks a raw NAND flash device through one complete page read. A controller gives it a page number and a one-clock start pulse. The block then drives the flash bus directly. It sends the read command and the column bytes, then the row bytes and a trailing address byte. For pages larger than one 512-byte chunk it also sends the confirm command. It then follows the ready/busy line through the array access and strobes the page out byte by byte. Each byte it reads goes to a byte-write port that names the 512-byte chunk and the offset inside it.

Device timing is given as fixed clock counts. Every command or address cycle holds WE# low for `T_PH` clocks and then high for `T_PH` clocks, and the flash latches on the rising edge. Every read strobe uses the same low/high split on RE#. The number of row bytes is not fixed when the block is built. It is found at run time by shifting a copy of (total pages − 1) right by eight bits after each byte, until that copy is empty. If the page number is larger than the page count, no row bytes are sent.

The state machine has these states: `S_IDLE`, `S_CMD_RD` (read command), `S_COL` (column bytes), `S_ROW` (row bytes), `S_TAIL` (trailing address), `S_CMD_CF` (confirm), `S_WAIT_LO` (wait for busy), `S_WAIT_HI` (wait for ready) and `S_DATA`. The transitions are:
- `S_IDLE` goes to `S_CMD_RD` on start.
- `S_CMD_RD` goes to `S_COL`.
- `S_COL` repeats once for large pages. It then goes to `S_ROW`, or to `S_TAIL` when the page is out of range.
- `S_ROW` repeats until the count is empty, then goes to `S_TAIL`.
- `S_TAIL` goes to `S_CMD_CF` for large pages, or to `S_WAIT_LO` for small pages.
- `S_CMD_CF` goes to `S_WAIT_LO`.
- `S_WAIT_LO` goes to `S_WAIT_HI`, and `S_WAIT_HI` goes to `S_DATA`.
- Either wait state goes back to `S_IDLE` on timeout.
- `S_DATA` goes back to `S_IDLE` after the last byte.

Top module: `nand_page_reader`

## Requirements
- R1: After reset the block is idle with CLE=0, ALE=0, WE#=1, RE#=1, done=0, err=0 and buf_we=0.
- R2: The first bus cycle of a read is a command cycle carrying byte 0x00, with CLE=1 and ALE=0.
- R3: Column bytes follow the read command as address cycles of value 0x00. There is one such byte when PAGE_BYTES is 512 and two when PAGE_BYTES is larger.
- R4: Row bytes are address cycles sent least significant byte first. After each byte, both the page number and a copy of TOTAL_PAGES−1 are shifted right by 8. Sending stops when the shifted copy is zero, so 65536 pages give two row bytes. When the page number exceeds TOTAL_PAGES, no row bytes are sent.
- R5: After the row bytes, one more address cycle of 0x00 is sent. When PAGE_BYTES exceeds 512, a command cycle of 0x30 follows it.
- R6: CLE and ALE are never high together. In each command or address cycle, WE# is low for exactly T_PH clocks and then high for T_PH clocks before the next cycle starts. The flash latches on the rising edge of WE#.
- R7: After the address phase, the block waits for R/B# to go low and then high. Each wait is limited to BUSY_TMO clocks. On a timeout, err goes to 1 and the block returns to idle with no done pulse and no buffer writes. The next start clears err.
- R8: The page is read as PAGE_BYTES RE# strobes, and RE# and WE# are never low together. Byte n is written to the buffer with buf_chunk = n/512 and buf_offset = n mod 512. Chunk 0 comes first and the bytes are in ascending order. buf_data is the I/O bus value at the end of each strobe.
- R9: done is high for exactly one clock, in the clock right after the last buffer write.
- R10: A start pulse while a read is in progress has no effect on the bus sequence, the data or the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock request to read a page |
| page_num | input | PAGE_NUM_W | Page to read, sampled on start |
| done | output | 1 | One-clock pulse after the last byte is stored |
| err | output | 1 | Set when a ready/busy wait times out; cleared by start |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the flash I/O bus |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte read from the flash I/O bus |
| nand_rb_n | input | 1 | Ready/busy from the flash, low when busy |
| buf_we | output | 1 | Buffer byte-write strobe |
| buf_chunk | output | CHUNK_W | 512-byte chunk index of the byte being written |
| buf_offset | output | 9 | Byte offset inside the chunk |
| buf_data | output | 8 | Byte being written |

## Verification
The hardest behaviours to reach from the ports are:
- the ready/busy timeout;
- the two page-number corners, one equal to the page count and one just above it;
- a second start that arrives while a read is already in progress.

The bench contains a small flash model. It pulls R/B# low for a fixed window after every rising edge of WE#, and a switch turns this response off so that the first wait times out. The model also puts a byte that depends on the page and the byte index on the bus at each falling edge of RE#. The vector table includes pages 0x10000 and 0x10001 so that both the quirk at the range boundary and the skipped row phase are covered. A directed run fires a second start, with a different page, ten clocks into a read.

// File: rtl/nprd_pkg.sv
package nprd_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_RD,
        S_COL,
        S_ROW,
        S_TAIL,
        S_CMD_CF,
        S_WAIT_LO,
        S_WAIT_HI,
        S_DATA
    } nprd_state_t;

    localparam logic [7:0] OP_READ0   = 8'h00;
    localparam logic [7:0] OP_CONFIRM = 8'h30;
    localparam logic [7:0] ADDR_ZERO  = 8'h00;
    localparam int         CHUNK_BYTES = 512;
endpackage

// File: rtl/nprd_phase_timer.sv
module nprd_phase_timer #(
    parameter int PH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic low,
    output logic last
);
    localparam int CW = (2 * PH > 1) ? $clog2(2 * PH) : 1;
    localparam logic [CW-1:0] LOW_END = CW'(PH);
    localparam logic [CW-1:0] LAST_V  = CW'(2 * PH - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign low  = run && (cnt < LOW_END);
    assign last = run && (cnt == LAST_V);

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_V); // R6
    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R6
endmodule

// File: rtl/nprd_row_addr.sv
module nprd_row_addr #(
    parameter int W     = 24,
    parameter int TOTAL = 65536
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] page_in,
    input  logic         shift,
    output logic [7:0]   row_byte,
    output logic         row_last,
    output logic         in_range
);
    localparam logic [W-1:0] CNT_INIT = W'(TOTAL - 1);
    localparam logic [W:0]   LIMIT    = (W + 1)'(TOTAL);

    logic [W-1:0] pg;
    logic [W-1:0] cnt;
    logic         rng;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg  <= '0;
            cnt <= '0;
            rng <= 1'b0;
        end else if (load) begin
            pg  <= page_in;
            cnt <= CNT_INIT;
            rng <= ({1'b0, page_in} <= LIMIT);
        end else if (shift) begin
            pg  <= pg >> 8;
            cnt <= cnt >> 8;
        end
    end

    assign row_byte = pg[7:0];
    assign row_last = ((cnt >> 8) == '0);
    assign in_range = rng;

    AST_ROW_LSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (row_byte == $past(page_in[7:0]))); // R4
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nprd_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int TOTAL_PAGES = 65536,
    parameter int PAGE_NUM_W  = 24,
    parameter int T_PH        = 2,
    parameter int BUSY_TMO    = 1000,
    localparam int NCHUNK     = PAGE_BYTES / CHUNK_BYTES,
    localparam int CHUNK_W    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [PAGE_NUM_W-1:0] page_num,
    output logic                  done,
    output logic                  err,
    output logic                  nand_cle,
    output logic                  nand_ale,
    output logic                  nand_we_n,
    output logic                  nand_re_n,
    output logic [7:0]            nand_io_out,
    output logic                  nand_io_oe,
    input  logic [7:0]            nand_io_in,
    input  logic                  nand_rb_n,
    output logic                  buf_we,
    output logic [CHUNK_W-1:0]    buf_chunk,
    output logic [8:0]            buf_offset,
    output logic [7:0]            buf_data
);
    localparam int  BYTE_W = $clog2(PAGE_BYTES);
    localparam int  TMO_W  = $clog2(BUSY_TMO + 1);
    localparam bit  LARGE  = (PAGE_BYTES > CHUNK_BYTES);
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
    localparam logic [TMO_W-1:0]  TMO_LAST  = TMO_W'(BUSY_TMO - 1);

    nprd_state_t       state, nxt;
    logic              col_second;
    logic [BYTE_W-1:0] bidx;
    logic [TMO_W-1:0]  tmo;
    logic              done_q, err_q;
    logic              run, ph_low, ph_last;
    logic              row_shift, row_last, in_range;
    logic [7:0]        row_byte;
    logic              launch, tmo_hit, is_wait;

    assign launch    = (state == S_IDLE) && start;
    assign is_wait   = (state == S_WAIT_LO) || (state == S_WAIT_HI);
    assign tmo_hit   = is_wait && (tmo == TMO_LAST);
    assign run       = (state == S_CMD_RD) || (state == S_COL) || (state == S_ROW) ||
                       (state == S_TAIL) || (state == S_CMD_CF) || (state == S_DATA);
    assign row_shift = (state == S_ROW) && ph_last;

    nprd_phase_timer #(.PH(T_PH)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .low  (ph_low),
        .last (ph_last)
    );

    nprd_row_addr #(.W(PAGE_NUM_W), .TOTAL(TOTAL_PAGES)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .page_in (page_num),
        .shift   (row_shift),
        .row_byte(row_byte),
        .row_last(row_last),
        .in_range(in_range)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_CMD_RD;
            S_CMD_RD:  if (ph_last) nxt = S_COL;
            S_COL:     if (ph_last) begin
                           if (LARGE && !col_second) nxt = S_COL;
                           else if (in_range)         nxt = S_ROW;
                           else                       nxt = S_TAIL;
                       end
            S_ROW:     if (ph_last && row_last) nxt = S_TAIL;
            S_TAIL:    if (ph_last) nxt = LARGE ? S_CMD_CF : S_WAIT_LO;
            S_CMD_CF:  if (ph_last) nxt = S_WAIT_LO;
            S_WAIT_LO: if (!nand_rb_n) nxt = S_WAIT_HI;
                       else if (tmo_hit) nxt = S_IDLE;
            S_WAIT_HI: if (nand_rb_n) nxt = S_DATA;
                       else if (tmo_hit) nxt = S_IDLE;
            S_DATA:    if (ph_last && (bidx == LAST_BYTE)) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            col_second <= 1'b0;
            bidx       <= '0;
            tmo        <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= (state == S_DATA) && ph_last && (bidx == LAST_BYTE);
            if (launch) begin
                col_second <= 1'b0;
                bidx       <= '0;
                err_q      <= 1'b0;
            end
            if ((state == S_COL) && ph_last) col_second <= 1'b1;
            if ((state == S_DATA) && ph_last) bidx <= bidx + 1'b1;
            if (!is_wait || (nxt != state)) tmo <= '0;
            else                            tmo <= tmo + 1'b1;
            if (tmo_hit && (nxt == S_IDLE)) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        nand_cle    = (state == S_CMD_RD) || (state == S_CMD_CF);
        nand_ale    = (state == S_COL) || (state == S_ROW) || (state == S_TAIL);
        nand_io_oe  = nand_cle || nand_ale;
        nand_we_n   = !(nand_io_oe && ph_low);
        nand_re_n   = !((state == S_DATA) && ph_low);
        unique case (state)
            S_CMD_CF: nand_io_out = OP_CONFIRM;
            S_ROW:    nand_io_out = row_byte;
            S_CMD_RD: nand_io_out = OP_READ0;
            default:  nand_io_out = ADDR_ZERO;
        endcase
        buf_we      = (state == S_DATA) && ph_last;
        buf_offset  = bidx[8:0];
        buf_data    = nand_io_in;
        done        = done_q;
        err         = err_q;
    end

    generate
        if (NCHUNK > 1) begin : g_multi_chunk
            assign buf_chunk = bidx[BYTE_W-1:9];
        end else begin : g_single_chunk
            assign buf_chunk = '0;
        end
    endgenerate

    AST_CMD_ADDR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(buf_we)); // R9
    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !done); // R7
endmodule

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;
    localparam int PB  = 2048;
    localparam int TP  = 65536;
    localparam int PW  = 24;
    localparam int TPH = 2;
    localparam int TMO = 1000;
    localparam int NV  = 5;
    // vector: page number, expected row-byte count
    localparam logic [27:0] VEC [NV] = '{
        {24'h000000, 4'd2}, {24'h001234, 4'd2}, {24'h00FFFF, 4'd2},
        {24'h010000, 4'd2}, {24'h010001, 4'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [PW-1:0] page_num = '0;
    logic done, err, cle, ale, we_n, re_n, io_oe, rb_n, buf_we;
    logic [7:0] io_out, buf_data;
    logic [7:0] io_in = 8'h00;
    logic [1:0] buf_chunk;
    logic [8:0] buf_offset;

    always #10 clk = ~clk;

    nand_page_reader #(.PAGE_BYTES(PB), .TOTAL_PAGES(TP), .PAGE_NUM_W(PW),
                       .T_PH(TPH), .BUSY_TMO(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .page_num(page_num),
        .done(done), .err(err), .nand_cle(cle), .nand_ale(ale),
        .nand_we_n(we_n), .nand_re_n(re_n), .nand_io_out(io_out),
        .nand_io_oe(io_oe), .nand_io_in(io_in), .nand_rb_n(rb_n),
        .buf_we(buf_we), .buf_chunk(buf_chunk), .buf_offset(buf_offset),
        .buf_data(buf_data)
    );

    int tests = 0, fails = 0, cyc = 0;
    int cur_page = 0, rd_idx = -1, wr_idx = 0, wr_bad = 0, last_wr = 0;
    int done_cnt = 0, done_gap = 0, low_run = 0, width_bad = 0;
    int log_n = 0, exp_n = 0;
    int log_v [32];
    int exp_v [32];
    bit dev_dead = 1'b0;
    logic we_d = 1'b1;
    int bcnt = 0;

    function automatic logic [7:0] pat(int pg, int i);
        return 8'((pg * 29) ^ (i * 7) ^ (i >> 5));
    endfunction

    // flash model: busy window after each WE# rise, data on RE# fall
    always @(posedge clk) begin
        we_d <= we_n;
        if (!dev_dead && we_n && !we_d) bcnt <= 1;
        else if (bcnt != 0 && bcnt < 30) bcnt <= bcnt + 1;
        else bcnt <= 0;
    end
    assign rb_n = !(bcnt >= 3 && bcnt <= 25);

    always @(negedge re_n) begin
        rd_idx = rd_idx + 1;
        io_in = pat(cur_page, rd_idx);
    end

    always @(posedge we_n) begin
        if (rst_n && log_n < 32) begin
            log_v[log_n] = {22'd0, cle, ale, io_out};
            log_n = log_n + 1;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (buf_we) begin
            if (buf_data !== pat(cur_page, wr_idx) || buf_chunk !== 2'(wr_idx / 512) ||
                buf_offset !== 9'(wr_idx % 512)) wr_bad = wr_bad + 1;
            wr_idx = wr_idx + 1;
            last_wr = cyc;
        end
        if (done === 1'b1) begin
            done_cnt = done_cnt + 1;
            done_gap = cyc - last_wr;
        end
        if (we_n === 1'b0) low_run = low_run + 1;
        else if (low_run != 0) begin
            if (low_run != TPH) width_bad = width_bad + 1;
            low_run = 0;
        end
        if (cyc > 195000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 195000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic build_exp(input int page);
        int p, c;
        exp_n = 0;
        exp_v[exp_n++] = 'h200;           // command 0x00
        exp_v[exp_n++] = 'h100;           // column 0
        exp_v[exp_n++] = 'h100;           // column 1 (page > 512)
        if (page <= TP) begin
            p = page; c = TP - 1;
            do begin
                exp_v[exp_n++] = 'h100 | (p & 'hFF);
                p = p >> 8; c = c >> 8;
            end while (c != 0);
        end
        exp_v[exp_n++] = 'h100;           // trailing address
        exp_v[exp_n++] = 'h230;           // confirm 0x30
    endtask

    int err_after_start = 0;

    task automatic run_page(input int page, input bit intrude);
        int wait_c;
        cur_page = page; rd_idx = -1; wr_idx = 0; wr_bad = 0;
        done_cnt = 0; width_bad = 0; log_n = 0; done_gap = 0;
        @(negedge clk);
        start = 1'b1; page_num = PW'(page);
        @(negedge clk);
        start = 1'b0;
        err_after_start = int'(err);
        wait_c = 0;
        while (!done && !err && wait_c < 20000) begin
            @(negedge clk);
            wait_c++;
            if (intrude && wait_c == 10) begin
                start = 1'b1; page_num = PW'('h99);
            end else begin
                start = 1'b0;
            end
        end
        repeat (5) @(negedge clk);
    endtask

    task automatic check_run(input string tag, input int rows);
        int mism = 0;
        int alec = 0;
        for (int k = 0; k < log_n; k++) if (log_v[k][8]) alec++;
        chk(alec == 2 + rows + 1, {tag, " R4 address cycle count"}, alec, 2 + rows + 1);
        chk(log_n == exp_n, {tag, " R5 bus cycle count"}, log_n, exp_n);
        for (int k = 0; k < exp_n && k < log_n; k++) if (log_v[k] != exp_v[k]) mism++;
        chk(mism == 0 && log_v[0] == 'h200, {tag, " R2 R3 R5 bus sequence"}, mism, 0);
        chk(width_bad == 0, {tag, " R6 WE# low width"}, width_bad, 0);
        chk(wr_idx == PB && wr_bad == 0, {tag, " R8 buffer writes"}, wr_bad + (wr_idx == PB ? 0 : 1000), 0);
        chk(done_cnt == 1 && done_gap == 1, {tag, " R9 done pulse"}, done_cnt * 10 + done_gap, 11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cle === 0 && ale === 0, "R1 CLE/ALE at reset", int'(cle) * 2 + int'(ale), 0);
        chk(we_n === 1 && re_n === 1, "R1 strobes at reset", int'(we_n) * 2 + int'(re_n), 3);
        chk(done === 0 && err === 0 && buf_we === 0, "R1 done/err/buf_we at reset",
            int'(done) + int'(err) + int'(buf_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(we_n === 1 && cle === 0, "R1 idle after reset release", int'(we_n), 1);

        for (int v = 0; v < NV; v++) begin
            build_exp(int'(VEC[v][27:4]));
            run_page(int'(VEC[v][27:4]), 1'b0);
            check_run($sformatf("vec%0d", v), int'(VEC[v][3:0]));
        end

        // R10 start while busy is ignored
        build_exp('h42);
        run_page('h42, 1'b1);
        check_run("R10 intrude", 2);

        // R7 timeout: device never goes busy
        dev_dead = 1'b1;
        build_exp(7);
        run_page(7, 1'b0);
        chk(err === 1'b1, "R7 err after timeout", int'(err), 1);
        chk(done_cnt == 0 && wr_idx == 0, "R7 no done, no writes on timeout", done_cnt + wr_idx, 0);
        chk(we_n === 1 && re_n === 1 && cle === 0 && ale === 0, "R7 bus idle after timeout",
            int'(we_n) + int'(re_n), 2);
        dev_dead = 1'b0;
        build_exp(8);
        run_page(8, 1'b0);
        chk(err_after_start == 0, "R7 err cleared by start", err_after_start, 0);
        check_run("R7 recovery", 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule